// File: doc/BRIEF.md
# Interval Timer with Prescaler

This block is an 8-bit down-counting interval timer. An outer bus decoder recognises a timer load and a timer count read. It passes each one on as a one-cycle strobe, together with the address bits that matter to the timer. On a load, the data byte becomes the count. The two low address bits of that write choose how many clocks pass between decrements: 1, 8, 64 or 1024. A third address bit sets the timer interrupt enable.

The count is always visible on an output for the outer read path. When the count passes below zero, a timeout flag is raised and handed to the interrupt logic, which places it at bit 7 of its interrupt flag byte. From that point on, the counter steps down once per clock, whatever the chosen rate, until the next load. This lets software measure how long ago the timeout happened.

Top module: `ivt_top`

## Requirements
- R1: While reset is asserted, the count output is 0x00 and both the timeout flag and the interrupt enable are 0.
- R2: A load strobe (tmr_wr) copies wr_data into the count, latches the rate from sel_rate and the enable from sel_irq, and clears the timeout flag. All of these are visible after the same clock edge.
- R3: sel_rate picks the decrement interval: 2'b00 every clock, 2'b01 every 8 clocks, 2'b10 every 64 clocks, 2'b11 every 1024 clocks. After a load of value D at edge k, the count first reads D-1 after edge k+interval.
- R4: cnt_out always shows the current count. A read strobe never changes the count.
- R5: At the edge where the count steps from 0x00 to 0xFF, the timeout flag goes to 1.
- R6: Once a timeout has occurred, the count decrements on every clock, regardless of the latched rate, until the next load.
- R7: A read strobe (tmr_rd) clears the timeout flag. If a timeout happens on the same edge, the flag is set instead.
- R8: A read strobe also loads the interrupt enable from sel_irq.
- R9: When tmr_wr and tmr_rd are both high, the load takes precedence: the count, rate, enable and cleared flag follow R2.
- R10: Without a strobe, the interrupt enable and the latched rate keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tmr_wr | input | 1 | Decoded timer load strobe |
| tmr_rd | input | 1 | Decoded timer count read strobe |
| sel_rate | input | 2 | Rate select address bits of the access |
| sel_irq | input | 1 | Interrupt enable address bit of the access |
| wr_data | input | 8 | Load value |
| cnt_out | output | 8 | Current count |
| tmo_flag | output | 1 | Timeout flag (bit 7 of the outer interrupt flag byte) |
| tmo_irq_en | output | 1 | Timer interrupt enable |

## Verification
The hardest case to reach from the ports is a read strobe that lands on the exact edge where the count wraps while the flag is already set. Only there does the set-over-clear priority of R7 show. The stimulus reaches it as follows. It lets a divide-by-1 load time out, counts off the 255 single-clock decrements of the fast phase, and issues the read while the count is at 0x00. The slow 1024 rate is also driven through a full timeout, so that the reload of the prescaler is covered across many periods.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    RATE_D1    = 2'b00,
    RATE_D8    = 2'b01,
    RATE_D64   = 2'b10,
    RATE_D1024 = 2'b11
  } rate_e;

  localparam int NUM_RATES = 4;

endpackage

// File: rtl/ivt_rst_sync.sv
module ivt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int SH1   = 3,
  parameter int SH2   = 6,
  parameter int SH3   = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  rate_e load_rate,
  input  rate_e cur_rate,
  input  logic  fast,
  output logic  tick
);

  localparam int SHIFTS [NUM_RATES] = '{0, SH1, SH2, SH3};

  logic [PRE_W-1:0] span_tab [NUM_RATES];
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_en;
  logic             pre_zero;

  // One reload value per rate: interval minus one
  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_span
    assign span_tab[gi] = PRE_W'((32'd1 << SHIFTS[gi]) - 32'd1);
  end

  assign pre_zero = (pre_q == '0);
  assign tick     = !load && (fast || pre_zero);
  assign pre_en   = load || !fast;

  always_comb begin
    pre_d = pre_q;
    if (load) begin
      pre_d = span_tab[load_rate];
    end else if (pre_zero) begin
      pre_d = span_tab[cur_rate];
    end else begin
      pre_d = pre_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load || tick;
  assign wrap   = tick && (cnt_q == '0);
  assign cnt    = cnt_q;

  always_comb begin
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  logic  rd,
  input  rate_e sel_rate,
  input  logic  sel_irq,
  input  logic  wrap,
  output rate_e rate,
  output logic  fast,
  output logic  flag,
  output logic  irq_en
);

  rate_e rate_q, rate_d;
  logic  fast_q, fast_d;
  logic  flag_q, flag_d;
  logic  en_q,   en_d;
  logic  upd;

  assign upd = wr || rd || wrap;

  always_comb begin
    rate_d = rate_q;
    fast_d = fast_q;
    flag_d = flag_q;
    en_d   = en_q;
    if (wr) begin
      rate_d = sel_rate;
      en_d   = sel_irq;
      flag_d = 1'b0;
      fast_d = 1'b0;
    end else begin
      if (rd) begin
        en_d = sel_irq;
      end
      if (wrap) begin
        flag_d = 1'b1;
        fast_d = 1'b1;
      end else if (rd) begin
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_D1;
      fast_q <= 1'b0;
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (upd) begin
      rate_q <= rate_d;
      fast_q <= fast_d;
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign rate   = rate_q;
  assign fast   = fast_q;
  assign flag   = flag_q;
  assign irq_en = en_q;

endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SH1         = 3,
  parameter int SH2         = 6,
  parameter int SH3         = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_wr,
  input  logic             tmr_rd,
  input  logic [1:0]       sel_rate,
  input  logic             sel_irq,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_out,
  output logic             tmo_flag,
  output logic             tmo_irq_en
);

  localparam int PRE_W = SH3;

  logic  rst_n_sync;
  logic  tick;
  logic  wrap;
  logic  fast;
  rate_e rate_cur;
  rate_e rate_sel;

  assign rate_sel = rate_e'(sel_rate);

  ivt_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_sync)
  );

  ivt_prescaler #(
    .PRE_W(PRE_W),
    .SH1  (SH1),
    .SH2  (SH2),
    .SH3  (SH3)
  ) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (tmr_wr),
    .load_rate(rate_sel),
    .cur_rate (rate_cur),
    .fast     (fast),
    .tick     (tick)
  );

  ivt_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load    (tmr_wr),
    .load_val(wr_data),
    .tick    (tick),
    .cnt     (cnt_out),
    .wrap    (wrap)
  );

  ivt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr      (tmr_wr),
    .rd      (tmr_rd),
    .sel_rate(rate_sel),
    .sel_irq (sel_irq),
    .wrap    (wrap),
    .rate    (rate_cur),
    .fast    (fast),
    .flag    (tmo_flag),
    .irq_en  (tmo_irq_en)
  );

endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wr,
  input logic             tmr_rd,
  input logic             sel_irq,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             en
);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> (cnt == $past(wr_data)) && !flag); // R2

  AST_ENABLE_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr || tmr_rd) |=> (en == $past(sel_irq))); // R8

  AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_wr || tmr_rd) |=> $stable(en)); // R10

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == '1) && ($past(cnt) == '0)); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) - 1'b1))); // R4

  AST_FAST_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !tmr_wr) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rd && !tmr_wr && (cnt != '0)) |=> !flag); // R7

endmodule

bind ivt_top ivt_chk #(
  .CNT_W(CNT_W)
) u_ivt_chk (
  .clk    (clk),
  .rst_n  (rst_n_sync),
  .tmr_wr (tmr_wr),
  .tmr_rd (tmr_rd),
  .sel_irq(sel_irq),
  .wr_data(wr_data),
  .cnt    (cnt_out),
  .flag   (tmo_flag),
  .en     (tmo_irq_en)
);

// File: tb/test_ivt_top.sv
`timescale 1ns/1ps
module test_ivt_top;

  logic       clk;
  logic       rst_n;
  logic       tmr_wr;
  logic       tmr_rd;
  logic [1:0] sel_rate;
  logic       sel_irq;
  logic [7:0] wr_data;
  logic [7:0] cnt_out;
  logic       tmo_flag;
  logic       tmo_irq_en;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference state
  bit model_on = 0;
  int m_cnt, m_wait, m_div;
  bit m_fast, m_flag, m_en;

  ivt_top i_ivt_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_wr    (tmr_wr),
    .tmr_rd    (tmr_rd),
    .sel_rate  (sel_rate),
    .sel_irq   (sel_irq),
    .wr_data   (wr_data),
    .cnt_out   (cnt_out),
    .tmo_flag  (tmo_flag),
    .tmo_irq_en(tmo_irq_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rate_clocks(logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 8;
      2'b10:   return 64;
      default: return 1024;
    endcase
  endfunction

  task automatic model_step();
    bit dec;
    bit wrapped;
    if (tmr_wr) begin
      m_cnt    = int'(wr_data);
      m_div    = rate_clocks(sel_rate);
      m_wait   = m_div;
      m_flag   = 0;
      m_fast   = 0;
      m_en     = sel_irq;
      model_on = 1;
    end else if (model_on) begin
      dec = 0;
      if (m_fast) begin
        dec = 1;
      end else begin
        m_wait--;
        if (m_wait == 0) begin
          dec    = 1;
          m_wait = m_div;
        end
      end
      wrapped = dec && (m_cnt == 0);
      if (dec) m_cnt = (m_cnt + 255) % 256;
      if (tmr_rd) m_en = sel_irq;
      if (wrapped) begin
        m_flag = 1;
        m_fast = 1;
      end else if (tmr_rd) begin
        m_flag = 0;
      end
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (model_on) begin
      chk("R4 count vs model", int'(cnt_out), m_cnt);
      chk("R5 flag vs model", int'(tmo_flag), int'(m_flag));
      chk("R8 enable vs model", int'(tmo_irq_en), int'(m_en));
    end
  endtask

  task automatic idle();
    tmr_wr = 1'b0;
    tmr_rd = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic do_write(logic [7:0] d, logic [1:0] r, logic irq);
    tmr_wr   = 1'b1;
    wr_data  = d;
    sel_rate = r;
    sel_irq  = irq;
    cycle();
    idle();
  endtask

  task automatic do_read(logic irq);
    tmr_rd  = 1'b1;
    sel_irq = irq;
    cycle();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    sel_rate = 2'b00;
    sel_irq  = 1'b0;
    wr_data  = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(cnt_out), 0);
    chk("R1 reset flag", int'(tmo_flag), 0);
    chk("R1 reset enable", int'(tmo_irq_en), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // divide-by-1 load and timeout
    do_write(8'h05, 2'b00, 1'b1);
    chk("R2 loaded count", int'(cnt_out), 5);
    chk("R2 enable latched", int'(tmo_irq_en), 1);
    chk("R2 flag cleared", int'(tmo_flag), 0);
    run(5);
    chk("R3 div1 reaches zero", int'(cnt_out), 0);
    chk("R3 no flag at zero", int'(tmo_flag), 0);
    run(1);
    chk("R5 wrap count", int'(cnt_out), 255);
    chk("R5 wrap flag", int'(tmo_flag), 1);
    run(3);
    chk("R6 fast decrement", int'(cnt_out), 8'hFC);

    do_read(1'b1);
    chk("R7 read clears flag", int'(tmo_flag), 0);
    chk("R4 read keeps stepping count", int'(cnt_out), 8'hFB);
    do_read(1'b0);
    chk("R8 read loads enable", int'(tmo_irq_en), 0);
    sel_irq = 1'b1;
    run(4);
    chk("R10 enable held without strobe", int'(tmo_irq_en), 0);

    // divide-by-8
    do_write(8'h03, 2'b01, 1'b0);
    run(7);
    chk("R3 div8 holds", int'(cnt_out), 3);
    run(1);
    chk("R3 div8 first step", int'(cnt_out), 2);

    // simultaneous load and read while timed out
    do_write(8'h00, 2'b00, 1'b1);
    run(1);
    chk("R5 flag before overlap", int'(tmo_flag), 1);
    tmr_wr   = 1'b1;
    tmr_rd   = 1'b1;
    wr_data  = 8'h09;
    sel_rate = 2'b10;
    sel_irq  = 1'b0;
    cycle();
    idle();
    sel_irq = 1'b1;
    chk("R9 load wins count", int'(cnt_out), 9);
    chk("R9 load wins flag", int'(tmo_flag), 0);
    chk("R9 load wins enable", int'(tmo_irq_en), 0);
    run(63);
    chk("R3 div64 holds", int'(cnt_out), 9);
    run(1);
    chk("R3 div64 first step", int'(cnt_out), 8);
    run(200);
    chk("R10 rate held", int'(cnt_out), 5);

    // read on the wrap edge with the flag already set
    do_write(8'h01, 2'b00, 1'b1);
    run(2);
    chk("R5 flag set", int'(tmo_flag), 1);
    run(255);
    chk("R6 fast back to zero", int'(cnt_out), 0);
    do_read(1'b1);
    chk("R7 wrap beats read", int'(tmo_flag), 1);
    chk("R7 wrap count", int'(cnt_out), 255);
    do_read(1'b1);
    chk("R7 later read clears", int'(tmo_flag), 0);

    // divide-by-1024 through a full timeout
    do_write(8'h02, 2'b11, 1'b1);
    run(1023);
    chk("R3 div1024 holds", int'(cnt_out), 2);
    run(1);
    chk("R3 div1024 first step", int'(cnt_out), 1);
    run(2047);
    chk("R3 div1024 at zero", int'(cnt_out), 0);
    chk("R5 no early flag", int'(tmo_flag), 0);
    run(1);
    chk("R5 div1024 timeout", int'(tmo_flag), 1);
    run(2);
    chk("R6 fast after slow rate", int'(cnt_out), 8'hFD);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule